// File: doc/BRIEF.md
# Speculative Load Tracker

This block is a small fully associative table that guards data loads the compiler has hoisted above earlier stores. When such a load executes, the pipeline writes a record into the table. The record holds the destination register tag, the aligned word address and the bytes the load touched. Every store that executes afterwards is snooped against all live records, and any record whose bytes overlap the store is dropped. Before the loaded value may be used, a check instruction queries the table by register tag. A hit means the speculation held. A miss means the load must be reissued by the recovery path.

Each of the 32 slots runs a two-state life cycle. A slot in `SLOT_FREE` moves to `SLOT_ARMED` when it is written. A slot in `SLOT_ARMED` stays armed when it is written again, and returns to `SLOT_FREE` on a flush, on an overlapping store, or on a check that asks for the record to be cleared. The check response path is a three-state machine. It enters `CK_HIT` or `CK_MISS` in the cycle after a check request, depending on whether the tag was found armed, and enters `CK_IDLE` after any cycle without a request. `rsp_vld` is high in `CK_HIT` and `CK_MISS`, and `rsp_hit` is high only in `CK_HIT`.

A new record goes to the armed slot that already holds its tag, or else to the lowest-numbered free slot. When every slot is armed, it goes to the slot named by a round-robin victim pointer.

Top module: `spec_load_tracker`

## Requirements
- R1: While reset is asserted and after it is released, every slot is free and `rsp_vld` is 0, so a check of any tag after reset misses.
- R2: An allocation (`alloc_vld`=1) arms a record for `alloc_tag`, and a later check of that tag reports a hit.
- R3: A check (`chk_vld`=1) produces `rsp_vld`=1 in the next cycle and only then, with `rsp_hit`=1 exactly when the tag was armed. The lookup sees the table as it stood before that cycle's store, allocation, clear or flush take effect.
- R4: Access size encoding is 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. The bytes covered are those from `addr[2:0]` upward, clipped at the end of the aligned 8-byte word. A store (`st_vld`=1) with the same `addr[ADDR_W-1:3]` and at least one common byte frees the record.
- R5: A store in a different aligned word, or one covering only other bytes of the same word, leaves the record armed.
- R6: An allocation to a tag that is already armed replaces that record's address and size. Stores to the old bytes no longer affect it, and stores to the new bytes do.
- R7: Free slots are filled lowest index first. When all slots are armed, a new tag replaces the slot at the victim pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each such replacement.
- R8: A hitting check with `chk_clr`=1 frees the record, so a later check misses. With `chk_clr`=0 the record stays armed.
- R9: A store and an allocation in the same cycle treat the store as older. The new record is armed even if the two overlap, while other armed records that the store overlaps are freed.
- R10: `flush`=1 frees every slot in one cycle, and an allocation presented in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Free all slots |
| alloc_vld | input | 1 | Record a speculative load |
| alloc_tag | input | TAG_W | Destination register tag of the load |
| alloc_addr | input | ADDR_W | Byte address read by the load |
| alloc_size | input | 2 | Load size code (0..3 = 1,2,4,8 bytes) |
| st_vld | input | 1 | Store snoop valid |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| chk_vld | input | 1 | Check request |
| chk_tag | input | TAG_W | Tag to check |
| chk_clr | input | 1 | Free the record if the check hits |
| rsp_vld | output | 1 | Check response valid, one cycle after request |
| rsp_hit | output | 1 | Record found armed |

## Verification
The hardest situation to reach from the ports is replacement when the table is full. The victim pointer only moves once all 32 slots are armed with distinct tags, so the stimulus first resets the block, then fills tags 0 to 31 in order, then allocates two new tags. Checks on the displaced and surviving tags show that the pointer walked from slot 0 to slot 1. Same-cycle interactions are reached by driving a store together with an allocation or a check in one vector. The store-and-allocate case covers both the new record and an older overlapping one, and the store-and-check case exposes the pre-update lookup.

// File: rtl/sltrk_pkg.sv
package sltrk_pkg;

    typedef enum logic {
        SLOT_FREE  = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        CK_IDLE = 2'd0,
        CK_HIT  = 2'd1,
        CK_MISS = 2'd2
    } ck_state_e;

    // Bytes touched inside the aligned 8-byte word, clipped at its end.
    function automatic logic [7:0] byte_lanes(input logic [2:0] ofs, input logic [1:0] sz);
        logic [7:0]  base;
        logic [15:0] wide;
        unique case (sz)
            2'd0:    base = 8'h01;
            2'd1:    base = 8'h03;
            2'd2:    base = 8'h0F;
            default: base = 8'hFF;
        endcase
        wide = {8'h00, base} << ofs;
        return wide[7:0];
    endfunction

endpackage

// File: rtl/sltrk_slot.sv
module sltrk_slot
    import sltrk_pkg::*;
#(
    parameter int TAG_W  = 7,
    parameter int WORD_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [7:0]        wr_lanes,
    input  logic              st_vld,
    input  logic [WORD_W-1:0] st_word,
    input  logic [7:0]        st_lanes,
    input  logic              clr_en,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              armed,
    output logic              alloc_match,
    output logic              chk_match
);

    slot_state_e       state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [WORD_W-1:0] word_q;
    logic [7:0]        lanes_q;
    logic              st_hit;

    assign armed       = (state_q == SLOT_ARMED);
    assign st_hit      = st_vld && (word_q == st_word) && (|(lanes_q & st_lanes));
    assign alloc_match = armed && (tag_q == alloc_tag);
    assign chk_match   = armed && (tag_q == chk_tag);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (!flush && wr_en) state_d = SLOT_ARMED;
            end
            SLOT_ARMED: begin
                if (flush)                 state_d = SLOT_FREE;
                else if (wr_en)            state_d = SLOT_ARMED;
                else if (st_hit || clr_en) state_d = SLOT_FREE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q   <= '0;
            word_q  <= '0;
            lanes_q <= '0;
        end else if (wr_en && !flush) begin
            tag_q   <= wr_tag;
            word_q  <= wr_word;
            lanes_q <= wr_lanes;
        end
    end

    p_flush_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !armed);

    p_write_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> armed);

    p_store_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && st_hit && !wr_en && !flush) |=> !armed);

    p_clear_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && clr_en && !wr_en && !flush) |=> !armed);

endmodule

// File: rtl/sltrk_alloc_sel.sv
module sltrk_alloc_sel #(
    parameter int N_ENTRIES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_go,
    input  logic [N_ENTRIES-1:0] armed,
    input  logic [N_ENTRIES-1:0] tag_hit,
    output logic [N_ENTRIES-1:0] wr_vec
);

    localparam int PTR_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_ENTRIES - 1);

    logic [PTR_W-1:0]     rr_q;
    logic [N_ENTRIES-1:0] free_pick;
    logic [N_ENTRIES-1:0] rr_onehot;
    logic                 any_free;
    logic                 replace;

    assign any_free  = ~&armed;
    assign rr_onehot = {{(N_ENTRIES-1){1'b0}}, 1'b1} << rr_q;
    assign replace   = alloc_go && !(|tag_hit) && !any_free;

    always_comb begin
        free_pick = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!armed[i]) begin
                free_pick    = '0;
                free_pick[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (!alloc_go)     wr_vec = '0;
        else if (|tag_hit) wr_vec = tag_hit;
        else if (any_free) wr_vec = free_pick;
        else               wr_vec = rr_onehot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rr_q <= '0;
        else if (replace) rr_q <= (rr_q == PTR_LAST) ? '0 : rr_q + 1'b1;
    end

    p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_go |-> $countones(wr_vec) == 1);

    p_no_write_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_go |-> wr_vec == '0);

endmodule

// File: rtl/sltrk_check_fsm.sv
module sltrk_check_fsm
    import sltrk_pkg::*;
#(
    parameter int N_ENTRIES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chk_vld,
    input  logic                 chk_clr,
    input  logic [N_ENTRIES-1:0] chk_match,
    output logic [N_ENTRIES-1:0] clr_vec,
    output logic                 rsp_vld,
    output logic                 rsp_hit
);

    ck_state_e ck_q, ck_d;

    assign clr_vec = (chk_vld && chk_clr) ? chk_match : '0;

    always_comb begin
        if (!chk_vld)        ck_d = CK_IDLE;
        else if (|chk_match) ck_d = CK_HIT;
        else                 ck_d = CK_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_q <= CK_IDLE;
        else        ck_q <= ck_d;
    end

    always_comb begin
        unique case (ck_q)
            CK_HIT:  begin rsp_vld = 1'b1; rsp_hit = 1'b1; end
            CK_MISS: begin rsp_vld = 1'b1; rsp_hit = 1'b0; end
            default: begin rsp_vld = 1'b0; rsp_hit = 1'b0; end
        endcase
    end

    p_rsp_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |=> rsp_vld);

    p_no_rsp_unasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_vld |=> !rsp_vld);

    p_unique_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_match));

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
    import sltrk_pkg::*;
#(
    parameter int N_ENTRIES = 32,
    parameter int TAG_W     = 7,
    parameter int ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_vld,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [1:0]        alloc_size,
    input  logic              st_vld,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_vld,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              chk_clr,
    output logic              rsp_vld,
    output logic              rsp_hit
);

    localparam int WORD_W = ADDR_W - 3;

    logic [N_ENTRIES-1:0] armed;
    logic [N_ENTRIES-1:0] alloc_match;
    logic [N_ENTRIES-1:0] chk_match;
    logic [N_ENTRIES-1:0] wr_vec;
    logic [N_ENTRIES-1:0] clr_vec;
    logic [7:0]           alloc_lanes;
    logic [7:0]           st_lanes;
    logic                 alloc_go;

    assign alloc_lanes = byte_lanes(alloc_addr[2:0], alloc_size);
    assign st_lanes    = byte_lanes(st_addr[2:0], st_size);
    assign alloc_go    = alloc_vld && !flush;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        sltrk_slot #(
            .TAG_W  (TAG_W),
            .WORD_W (WORD_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush       (flush),
            .wr_en       (wr_vec[g]),
            .wr_tag      (alloc_tag),
            .wr_word     (alloc_addr[ADDR_W-1:3]),
            .wr_lanes    (alloc_lanes),
            .st_vld      (st_vld),
            .st_word     (st_addr[ADDR_W-1:3]),
            .st_lanes    (st_lanes),
            .clr_en      (clr_vec[g]),
            .alloc_tag   (alloc_tag),
            .chk_tag     (chk_tag),
            .armed       (armed[g]),
            .alloc_match (alloc_match[g]),
            .chk_match   (chk_match[g])
        );
    end

    sltrk_alloc_sel #(
        .N_ENTRIES (N_ENTRIES)
    ) u_alloc_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_go (alloc_go),
        .armed    (armed),
        .tag_hit  (alloc_match),
        .wr_vec   (wr_vec)
    );

    sltrk_check_fsm #(
        .N_ENTRIES (N_ENTRIES)
    ) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_vld   (chk_vld),
        .chk_clr   (chk_clr),
        .chk_match (chk_match),
        .clr_vec   (clr_vec),
        .rsp_vld   (rsp_vld),
        .rsp_hit   (rsp_hit)
    );

    p_alloc_tag_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_match));

    p_flush_empties_table_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> armed == '0);

endmodule

// File: tb/sim_spec_load_tracker.sv
module sim_spec_load_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        alloc_vld = 1'b0;
    logic [6:0]  alloc_tag = '0;
    logic [31:0] alloc_addr = '0;
    logic [1:0]  alloc_size = '0;
    logic        st_vld = 1'b0;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic        chk_vld = 1'b0;
    logic [6:0]  chk_tag = '0;
    logic        chk_clr = 1'b0;
    logic        rsp_vld;
    logic        rsp_hit;

    int n_chk = 0;
    int n_err = 0;

    spec_load_tracker u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_vld(alloc_vld), .alloc_tag(alloc_tag), .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .st_vld(st_vld), .st_addr(st_addr), .st_size(st_size),
        .chk_vld(chk_vld), .chk_tag(chk_tag), .chk_clr(chk_clr),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic        a;
        logic [6:0]  atag;
        logic [31:0] aaddr;
        logic [1:0]  asz;
        logic        s;
        logic [31:0] saddr;
        logic [1:0]  ssz;
        logic        c;
        logic [6:0]  ctag;
        logic        cclr;
        logic        ev;
        logic        eh;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 7'd1, 32'h100, 2'd3, 1'b0, 32'h0,   2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 alloc t1
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd1, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 hit
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd2, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 miss
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b1, 32'h108, 2'd3, 1'b1, 7'd1, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 other word
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd1, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b1, 7'd2, 32'h200, 2'd1, 1'b0, 32'h0,   2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b1, 32'h202, 2'd1, 1'b1, 7'd2, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 disjoint bytes
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd2, 1'b0, 1'b1, 1'b1, 4'd5},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b1, 32'h201, 2'd0, 1'b1, 7'd2, 1'b0, 1'b1, 1'b1, 4'd3},  // R3 pre-update lookup
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd2, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 byte overlap
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b1, 32'h104, 2'd2, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 upper half
        '{1'b1, 7'd3, 32'h300, 2'd2, 1'b0, 32'h0,   2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 7'd3, 32'h400, 2'd2, 1'b0, 32'h0,   2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 overwrite
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b1, 32'h300, 2'd2, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd3, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 old bytes ignored
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b1, 32'h402, 2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd3, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 new bytes tracked
        '{1'b1, 7'd4, 32'h500, 2'd3, 1'b1, 32'h500, 2'd3, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 store older
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd4, 1'b0, 1'b1, 1'b1, 4'd9},
        '{1'b1, 7'd5, 32'h600, 2'd0, 1'b0, 32'h0,   2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd8},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd5, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 no clear
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd5, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 clear
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd5, 1'b0, 1'b1, 1'b0, 4'd8},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd9, 1'b0, 1'b1, 1'b0, 4'd3},
        '{1'b1, 7'd6, 32'h706, 2'd2, 1'b0, 32'h0,   2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 clipped range
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b1, 32'h708, 2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd6, 1'b0, 1'b1, 1'b1, 4'd4},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b1, 32'h707, 2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd6, 1'b0, 1'b1, 1'b0, 4'd4},
        '{1'b1, 7'd7, 32'h800, 2'd3, 1'b0, 32'h0,   2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 7'd8, 32'h800, 2'd3, 1'b1, 32'h800, 2'd0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 older record freed
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd7, 1'b0, 1'b1, 1'b0, 4'd9},
        '{1'b0, 7'd0, 32'h0,   2'd0, 1'b0, 32'h0,   2'd0, 1'b1, 7'd8, 1'b0, 1'b1, 1'b1, 4'd9}
    };

    task automatic expect_rsp(input string req, input logic ev, input logic eh);
        n_chk++;
        if (rsp_vld !== ev || (ev && rsp_hit !== eh)) begin
            n_err++;
            $display("FAIL %s: rsp_vld=%b rsp_hit=%b expected %b/%b", req, rsp_vld, rsp_hit, ev, eh);
        end
    endtask

    // One clock: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic cyc(input logic a, input logic [6:0] at, input logic [31:0] aa, input logic [1:0] asz,
                       input logic s, input logic [31:0] sa, input logic [1:0] ssz,
                       input logic c, input logic [6:0] ct, input logic cc, input logic fl);
        @(negedge clk);
        alloc_vld = a; alloc_tag = at; alloc_addr = aa; alloc_size = asz;
        st_vld = s; st_addr = sa; st_size = ssz;
        chk_vld = c; chk_tag = ct; chk_clr = cc; flush = fl;
        @(posedge clk);
        #1;
        alloc_vld = 1'b0; st_vld = 1'b0; chk_vld = 1'b0; chk_clr = 1'b0; flush = 1'b0;
    endtask

    task automatic do_check(input logic [6:0] t, input string req, input logic eh);
        cyc(1'b0, 7'd0, 32'h0, 2'd0, 1'b0, 32'h0, 2'd0, 1'b1, t, 1'b0, 1'b0);
        expect_rsp(req, 1'b1, eh);
    endtask

    task automatic do_alloc(input logic [6:0] t, input logic [31:0] addr);
        cyc(1'b1, t, addr, 2'd3, 1'b0, 32'h0, 2'd0, 1'b0, 7'd0, 1'b0, 1'b0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        expect_rsp("R1 during reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_rsp("R1 held in reset", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        do_check(7'd1, "R1 empty after reset", 1'b0);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].a, VEC[i].atag, VEC[i].aaddr, VEC[i].asz,
                VEC[i].s, VEC[i].saddr, VEC[i].ssz,
                VEC[i].c, VEC[i].ctag, VEC[i].cclr, 1'b0);
            expect_rsp($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].ev, VEC[i].eh);
        end

        // R1: reset frees a record that was armed (tag 4)
        apply_reset();
        do_check(7'd4, "R1 cleared by reset", 1'b0);

        // R7: fill every slot, then replace twice
        apply_reset();
        for (int t = 0; t < 32; t++) do_alloc(7'(t), 32'h1000 + 32'(t) * 32'd8);
        do_check(7'd31, "R7 table full", 1'b1);
        do_alloc(7'd40, 32'h2000);
        do_check(7'd0, "R7 first victim slot 0", 1'b0);
        do_check(7'd1, "R7 slot 1 kept", 1'b1);
        do_alloc(7'd41, 32'h2008);
        do_check(7'd1, "R7 second victim slot 1", 1'b0);
        do_check(7'd2, "R7 slot 2 kept", 1'b1);
        do_check(7'd40, "R7 new record", 1'b1);
        do_check(7'd41, "R7 new record", 1'b1);

        // R10: flush with a simultaneous allocation
        cyc(1'b1, 7'd50, 32'h3000, 2'd3, 1'b0, 32'h0, 2'd0, 1'b0, 7'd0, 1'b0, 1'b1);
        expect_rsp("R10 no response", 1'b0, 1'b0);
        do_check(7'd50, "R10 alloc dropped", 1'b0);
        do_check(7'd40, "R10 flushed", 1'b0);
        do_check(7'd2, "R10 flushed", 1'b0);
        do_check(7'd31, "R10 flushed", 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule